// File: doc/BRIEF.md
# Configurable Byte-Wide GPIO Port

This block is one general-purpose I/O port of a small microcontroller. Software writes four per-pin control registers through a simple write interface: an output data latch, a direction mask, an open-drain mask and a pull-up mask. From these the port derives, for each pin, an output enable, an output value and a pull-up request for a tri-state pad. A read interface returns any control register, or the pad input levels after a two-flop synchronizer.

On-chip peripherals can take over pins. A per-pin alternate-function select gates a peripheral output with the data latch. A per-pin PWM enable forces that pin to drive the PWM level. A keypad scanner enable forces either every pin to a pulled-up input (row mode) or a low-order group of pins to open-drain column drivers (column mode). The keypad always takes priority over a PWM override. The output enable is worked out only after all overrides are applied.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch, direction, open-drain and pull-up registers all read 0, every pad_oe bit is 0 and every pad_pu bit is 0.
- R2: A write with wr_addr 0 (latch), 1 (direction), 2 (open-drain) or 3 (pull-up) is stored at the clock edge. It reads back from the same rd_addr on the next cycle. A write to addr 4 to 7 changes no register and no pad output.
- R3: rd_addr 4 returns pad_in through a two-flop synchronizer. A change set up before clock edge k is not visible after edge k but is visible after edge k+1. rd_addr 5 to 7 read 0.
- R4: With no override active, a pin whose direction bit is 0 has pad_oe 0.
- R5: With no override active, a pin with direction 1 and open-drain 0 has pad_oe 1 and pad_do equal to its latch bit.
- R6: With no override active, a pin with direction 1 and open-drain 1 has pad_oe 1 only when its value is 0. pad_do carries the value.
- R7: With no keypad row mode, pad_pu of a pin equals its pull-up register bit.
- R8: When alt_sel of a pin is 1, its output value is latch AND alt_out. Direction and open-drain still apply.
- R9: When pwm_en of a pin is 1 and no keypad override covers it, the pin drives push-pull with pad_oe 1 and pad_do equal to pwm_val. This holds whatever the direction and open-drain bits are.
- R10: With kp_en 1 and kp_col_mode 0, every pin has pad_oe 0 and pad_pu 1.
- R11: With kp_en 1 and kp_col_mode 1, pins 0 through kp_col_last (kp_col_last+1 pins, 1 to 8) are open-drain drivers of kp_col_drv. Other pins keep their normal or PWM behaviour.
- R12: A keypad override on a pin takes priority over a PWM enable on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register select (4 = synchronized pins) |
| rd_data | output | 8 | Read data |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin pad output enable |
| pad_do | output | 8 | Per-pin pad output value |
| pad_pu | output | 8 | Per-pin pull-up request |
| alt_sel | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Alternate-function output levels |
| pwm_en | input | 8 | Per-pin PWM override enable |
| pwm_val | input | 8 | PWM output levels |
| kp_en | input | 1 | Keypad scanner enable |
| kp_col_mode | input | 1 | 1 = column mode, 0 = row mode |
| kp_col_last | input | 3 | Index of the highest column pin |
| kp_col_drv | input | 8 | Column drive levels from the scanner |

## Verification
The hardest cases are the overlaps: a pin that the keypad and PWM both claim, and a column-mode pin whose registers ask for push-pull or input. In both cases the override must win. The stimulus gets there by building up register state first, with open-drain set on some pins and the direction cleared on others. It then turns on PWM and the keypad in stages, with PWM still on when column mode is entered at both a narrow and the full column count. Synchronizer latency is checked one cycle early and on time after a pad change.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      REG_LATCH = 3'd0,
      REG_DIR   = 3'd1,
      REG_OD    = 3'd2,
      REG_PU    = 3'd3,
      REG_PINS  = 3'd4
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [WIDTH-1:0]  pins_sync,
   output logic [WIDTH-1:0]  lat_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  od_q,
   output logic [WIDTH-1:0]  pu_q,
   output logic [WIDTH-1:0]  rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '0;
         od_q  <= '0;
         pu_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_LATCH: lat_q <= wr_data;
            REG_DIR:   dir_q <= wr_data;
            REG_OD:    od_q  <= wr_data;
            REG_PU:    pu_q  <= wr_data;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         REG_LATCH: rd_data = lat_q;
         REG_DIR:   rd_data = dir_q;
         REG_OD:    rd_data = od_q;
         REG_PU:    rd_data = pu_q;
         REG_PINS:  rd_data = pins_sync;
         default:   rd_data = '0;
      endcase
   end

   // R2: a write to a control register lands at the edge
   p_dir_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_DIR) |=> (dir_q == $past(wr_data)));
   p_latch_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_LATCH) |=> (lat_q == $past(wr_data)));
   // R2: writes outside the register window change nothing
   p_bad_addr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= REG_PINS) |=>
         ($stable(lat_q) && $stable(dir_q) && $stable(od_q) && $stable(pu_q)));
endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell (
   input  logic lat_bit,
   input  logic dir_bit,
   input  logic od_bit,
   input  logic pu_bit,
   input  logic alt_sel,
   input  logic alt_out,
   input  logic pwm_en,
   input  logic pwm_val,
   input  logic kp_row,
   input  logic kp_col,
   input  logic col_drv,
   output logic oe,
   output logic dout,
   output logic pull
);
   logic eff_dir, eff_val, eff_od, eff_pu;

   always_comb begin
      eff_dir = dir_bit;
      eff_val = alt_sel ? (lat_bit & alt_out) : lat_bit;
      eff_od  = od_bit;
      eff_pu  = pu_bit;
      if (pwm_en) begin
         eff_dir = 1'b1;
         eff_val = pwm_val;
         eff_od  = 1'b0;
      end
      if (kp_row) begin
         eff_dir = 1'b0;
         eff_od  = 1'b0;
         eff_pu  = 1'b1;
      end else if (kp_col) begin
         eff_dir = 1'b1;
         eff_od  = 1'b1;
         eff_val = col_drv;
      end
      oe   = eff_dir & ~(eff_od & eff_val);
      dout = eff_val;
      pull = eff_pu;
   end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_do,
   output logic [WIDTH-1:0]  pad_pu,
   input  logic [WIDTH-1:0]  alt_sel,
   input  logic [WIDTH-1:0]  alt_out,
   input  logic [WIDTH-1:0]  pwm_en,
   input  logic [WIDTH-1:0]  pwm_val,
   input  logic              kp_en,
   input  logic              kp_col_mode,
   input  logic [CNT_W-1:0]  kp_col_last,
   input  logic [WIDTH-1:0]  kp_col_drv
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_port: WIDTH must be 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] lat_q, dir_q, od_q, pu_q, pins_sync, col_mask;
   logic             kp_row;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pins_sync)
   );

   gpio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .pins_sync(pins_sync),
      .lat_q(lat_q), .dir_q(dir_q), .od_q(od_q), .pu_q(pu_q),
      .rd_data(rd_data)
   );

   assign kp_row = kp_en & ~kp_col_mode;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         localparam logic [CNT_W:0] IDX = (CNT_W+1)'(i);
         assign col_mask[i] = kp_en & kp_col_mode & (IDX <= {1'b0, kp_col_last});
         gpio_pin_cell u_cell (
            .lat_bit(lat_q[i]), .dir_bit(dir_q[i]), .od_bit(od_q[i]),
            .pu_bit(pu_q[i]), .alt_sel(alt_sel[i]), .alt_out(alt_out[i]),
            .pwm_en(pwm_en[i]), .pwm_val(pwm_val[i]), .kp_row(kp_row),
            .kp_col(col_mask[i]), .col_drv(kp_col_drv[i]),
            .oe(pad_oe[i]), .dout(pad_do[i]), .pull(pad_pu[i])
         );
      end
   endgenerate

   // R4: input pins never drive
   p_input_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !kp_en |-> ((pad_oe & ~dir_q & ~pwm_en) == '0));
   // R6: open-drain pins never drive a high level
   p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !kp_en |-> ((pad_oe & pad_do & od_q & ~pwm_en) == '0));
   // R9: PWM forces push-pull drive of its level
   p_pwm_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !kp_en |-> (((pwm_en & ~pad_oe) == '0) && (((pad_do ^ pwm_val) & pwm_en) == '0)));
   // R10: row mode makes every pin a pulled-up input
   p_row_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kp_en && !kp_col_mode) |-> ((pad_oe == '0) && (&pad_pu)));
   // R11: column pins only pull low and carry the scanner level
   p_col_low_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kp_en && kp_col_mode) |->
         (((pad_oe & pad_do & col_mask) == '0) && (((pad_do ^ kp_col_drv) & col_mask) == '0)));
   // R12: keypad beats PWM in row mode
   p_kp_beats_pwm_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (kp_en && !kp_col_mode) |-> ((pad_oe & pwm_en) == '0));

   // R3: synchronizer latency, checked once history since reset is long enough
   logic [1:0] settle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                settle_q <= '0;
      else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
   end
   generate
      if (SYNC_STAGES == 2) begin : g_lat_chk
         p_sync_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (settle_q >= 2'd2) |-> (pins_sync == $past(pad_in, 2)));
      end
   endgenerate
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_oe, pad_do, pad_pu;
   logic [7:0] alt_sel = '0, alt_out = '0, pwm_en = '0, pwm_val = '0;
   logic       kp_en = 1'b0, kp_col_mode = 1'b0;
   logic [2:0] kp_col_last = '0;
   logic [7:0] kp_col_drv = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      string      tag;
      logic [7:0] oe, dout, pu, rd;
   } exp_t;
   exp_t sb_q[$];

   logic [7:0] s_lat = '0, s_dir = '0, s_od = '0, s_pu = '0, pin_seen = '0;

   always #2 clk = ~clk;

   gpio_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
      .alt_sel(alt_sel), .alt_out(alt_out), .pwm_en(pwm_en), .pwm_val(pwm_val),
      .kp_en(kp_en), .kp_col_mode(kp_col_mode), .kp_col_last(kp_col_last),
      .kp_col_drv(kp_col_drv)
   );

   // Expected pad behaviour built from the requirement list
   function automatic exp_t model(string tag);
      exp_t e;
      e.tag = tag;
      for (int i = 0; i < 8; i++) begin
         logic d, v, o, p;
         d = s_dir[i]; o = s_od[i]; p = s_pu[i];
         v = alt_sel[i] ? (s_lat[i] & alt_out[i]) : s_lat[i];   // R5, R8
         if (pwm_en[i]) begin d = 1; v = pwm_val[i]; o = 0; end // R9
         if (kp_en && !kp_col_mode) begin d = 0; o = 0; p = 1; end // R10
         else if (kp_en && kp_col_mode && i <= int'(kp_col_last)) begin
            d = 1; o = 1; v = kp_col_drv[i];                   // R11, R12
         end
         e.oe[i] = d & ~(o & v);                                // R4, R6
         e.dout[i] = v;
         e.pu[i] = p;                                           // R7
      end
      case (rd_addr)
         3'd0: e.rd = s_lat;
         3'd1: e.rd = s_dir;
         3'd2: e.rd = s_od;
         3'd3: e.rd = s_pu;
         3'd4: e.rd = pin_seen;
         default: e.rd = '0;
      endcase
      return e;
   endfunction

   // Driver side: push an expectation, let the monitor take it, move to next negedge
   task automatic check(string tag);
      sb_q.push_back(model(tag));
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      case (a)
         3'd0: s_lat = d;
         3'd1: s_dir = d;
         3'd2: s_od = d;
         3'd3: s_pu = d;
         default: ;
      endcase
   endtask

   // Monitor: compare as results appear
   initial begin
      forever begin
         exp_t e;
         wait (sb_q.size() != 0);
         #1;
         e = sb_q.pop_front();
         checks++;
         if (pad_oe !== e.oe || pad_do !== e.dout || pad_pu !== e.pu || rd_data !== e.rd) begin
            failures++;
            $display("FAIL %s: oe=%h/%h do=%h/%h pu=%h/%h rd=%h/%h (actual/expected)",
                     e.tag, pad_oe, e.oe, pad_do, e.dout, pad_pu, e.pu, rd_data, e.rd);
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      for (int a = 0; a < 4; a++) begin
         rd_addr = 3'(a);
         check("R1 reset state");
      end
      rd_addr = 0;
      wr(3'd0, 8'hA5);
      check("R2 latch readback / R4 inputs idle");
      rd_addr = 1;
      wr(3'd1, 8'hFF);
      check("R5 push-pull drive");
      rd_addr = 2;
      wr(3'd2, 8'h0F);
      check("R6 open-drain low only");
      rd_addr = 3;
      wr(3'd3, 8'h3C);
      check("R7 pull-up follows register");
      wr(3'd5, 8'h00);
      wr(3'd7, 8'h00);
      for (int a = 0; a < 4; a++) begin
         rd_addr = 3'(a);
         check("R2 out-of-window write ignored");
      end
      rd_addr = 6;
      check("R3 unused read address is zero");
      alt_sel = 8'hF0; alt_out = 8'h3C;
      check("R8 alternate gated by latch");
      alt_sel = 8'hFF; alt_out = 8'h0F;
      check("R8 alternate on open-drain pins");
      wr(3'd1, 8'h0F);
      check("R4 inputs do not drive with alternate on");
      wr(3'd2, 8'hFF);
      pwm_en = 8'hC1; pwm_val = 8'h40;
      check("R9 pwm forces push-pull");
      kp_en = 1;
      check("R10 row mode pulled-up inputs / R12");
      kp_col_mode = 1; kp_col_last = 3'd2; kp_col_drv = 8'h05;
      check("R11 three column pins");
      kp_col_last = 3'd0; kp_col_drv = 8'h00;
      check("R11 single column pin");
      kp_col_last = 3'd7; kp_col_drv = 8'h0F;
      check("R12 full columns beat pwm");
      kp_en = 0; kp_col_mode = 0; pwm_en = 0; alt_sel = 0;
      check("R9 overrides released");
      rd_addr = 4;
      pad_in = 8'h5A;
      @(negedge clk);
      check("R3 pin not yet visible after one edge");
      pin_seen = 8'h5A;
      check("R3 pin visible after two edges");
      pad_in = 8'hC3;
      @(negedge clk);
      check("R3 second change still old");
      pin_seen = 8'hC3;
      check("R3 second change visible");
      wait (sb_q.size() == 0);
      #2;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule